// File: doc/BRIEF.md
# Multi-Granularity Vector Blend Unit

This block merges two 128-bit vectors, a destination and a source, one element at a time. For each element, the result takes the source value or keeps the destination value, under a per-element select. The select comes from one of two places. In immediate modes it comes from an 8-bit immediate. In variable modes it comes from the top bit of each element of a third vector. The element width is 8, 16, 32 or 64 bits, and the opcode picks it for each operation.

An operation is issued by raising `in_valid_i` for one cycle. During that cycle the opcode, the immediate and the three vectors must be present. The result is registered and appears one clock later together with `out_valid_o`. It stays on the output until the next accepted operation.

Top module: `simd_blend`

## Requirements
- R1: Opcode 3'b000 (variable byte): byte i of the result is source byte i when mask bit 8i+7 is 1, and destination byte i otherwise.
- R2: Opcode 3'b001 (immediate 16-bit): imm bit i selects the source for 16-bit element i, where element 0 is bits 15:0.
- R3: Opcode 3'b010 (immediate 32-bit): imm bit i (i = 0..3) selects the source for 32-bit element i; imm bits 7:4 have no effect.
- R4: Opcode 3'b011 (immediate 64-bit): imm bit i (i = 0..1) selects the source for 64-bit element i; imm bits 7:2 have no effect.
- R5: Opcode 3'b100 (variable 32-bit): 32-bit element i comes from the source when mask bit 32i+31 is 1.
- R6: Opcode 3'b101 (variable 64-bit): 64-bit element i comes from the source when mask bit 64i+63 is 1.
- R7: The mask vector has no effect in the immediate modes, and the immediate has no effect in the variable modes.
- R8: Opcodes 3'b110 and 3'b111 return the destination vector unchanged.
- R9: `out_valid_o` is high in exactly the cycle after an accepted operation, and `res_o` carries that operation's result in the same cycle.
- R10: When `in_valid_i` is low, `out_valid_o` goes low on the next cycle and `res_o` keeps its value, whatever the other inputs do.
- R11: While `rst_ni` is low, `out_valid_o` and `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Blend mode and element size |
| imm_i | input | 8 | Immediate select bits |
| dst_i | input | 128 | Destination operand |
| src_i | input | 128 | Source operand |
| mask_i | input | 128 | Variable-mode select vector |
| out_valid_o | output | 1 | Result valid, one cycle after in_valid_i |
| res_o | output | 128 | Blended vector |

## Verification
The bench sets some mask bytes so that the top bit of a byte is 1 while the top bit of the enclosing 32-bit or 64-bit element is 0. A design that takes the wrong bit position for the element would then select the wrong element. Immediate values carry 1s in the high bits that the 32-bit and 64-bit modes must ignore, so a design that aliases element indices would corrupt the upper elements. Each mode is run twice with two different values of the input it must ignore, and both unused opcodes are issued: a leak of the mask into an immediate mode, or the reverse, shows up as a data mismatch. Idle cycles with changing inputs catch a result register that loads without a valid strobe.

// File: rtl/simd_blend_pkg.sv
package simd_blend_pkg;

  localparam int unsigned IMM_W = 8;

  typedef enum logic [2:0] {
    OP_VAR_B = 3'b000,
    OP_IMM_W = 3'b001,
    OP_IMM_D = 3'b010,
    OP_IMM_Q = 3'b011,
    OP_VAR_D = 3'b100,
    OP_VAR_Q = 3'b101
  } blend_op_e;

endpackage

// File: rtl/simd_blend_sel.sv
// Expands immediate or vector mask into one select bit per byte lane.
module simd_blend_sel
  import simd_blend_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NB   = VEC_W / 8
) (
  input  logic [2:0]       op_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [VEC_W-1:0] mask_i,
  output logic [NB-1:0]    sel_o
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam int unsigned WI = b / 2;
    localparam int unsigned DI = b / 4;
    localparam int unsigned QI = b / 8;

    logic imm_w, imm_d, imm_q;
    // element index beyond the immediate width never selects the source
    assign imm_w = (WI < IMM_W) ? imm_i[WI % IMM_W] : 1'b0;
    assign imm_d = (DI < IMM_W) ? imm_i[DI % IMM_W] : 1'b0;
    assign imm_q = (QI < IMM_W) ? imm_i[QI % IMM_W] : 1'b0;

    always_comb begin
      case (op_i)
        OP_VAR_B: sel_o[b] = mask_i[8*b + 7];
        OP_IMM_W: sel_o[b] = imm_w;
        OP_IMM_D: sel_o[b] = imm_d;
        OP_IMM_Q: sel_o[b] = imm_q;
        OP_VAR_D: sel_o[b] = mask_i[32*DI + 31];
        OP_VAR_Q: sel_o[b] = mask_i[64*QI + 63];
        default:  sel_o[b] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/simd_blend_merge.sv
module simd_blend_merge #(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NB   = VEC_W / 8
) (
  input  logic [NB-1:0]    sel_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [VEC_W-1:0] src_i,
  output logic [VEC_W-1:0] res_o
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign res_o[8*b +: 8] = sel_i[b] ? src_i[8*b +: 8] : dst_i[8*b +: 8];
  end

endmodule

// File: rtl/simd_blend.sv
module simd_blend
  import simd_blend_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NB   = VEC_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [2:0]       op_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] mask_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] res_o
);

  logic [NB-1:0]    sel;
  logic [VEC_W-1:0] blend_d;
  logic [VEC_W-1:0] res_q;
  logic             vld_q;

  simd_blend_sel #(.VEC_W(VEC_W)) u_sel (
    .op_i   (op_i),
    .imm_i  (imm_i),
    .mask_i (mask_i),
    .sel_o  (sel)
  );

  simd_blend_merge #(.VEC_W(VEC_W)) u_merge (
    .sel_i (sel),
    .dst_i (dst_i),
    .src_i (src_i),
    .res_o (blend_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) res_q <= blend_d;
    end
  end

  assign out_valid_o = vld_q;
  assign res_o       = res_q;

  p_valid_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  p_valid_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(res_o));

  p_passthru_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i[2] && op_i[1]) |=> (res_o == $past(dst_i)));

  p_no_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[2] && op_i[1]) |-> (sel == '0));

  p_full_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_IMM_W && imm_i == 8'hFF) |=> (res_o == $past(src_i)));

endmodule

// File: tb/simd_blend_tb.sv
module simd_blend_tb;
  localparam int VW = 128;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    op = '0;
  logic [7:0]    imm = '0;
  logic [VW-1:0] dst = '0, src = '0, msk = '0;
  logic          out_valid;
  logic [VW-1:0] res;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  simd_blend u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .op_i        (op),
    .imm_i       (imm),
    .dst_i       (dst),
    .src_i       (src),
    .mask_i      (msk),
    .out_valid_o (out_valid),
    .res_o       (res)
  );

  // table rows use dst = 0, src = all ones, so expected = select pattern
  localparam logic [2:0] T_OP [NV] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam logic [7:0] T_IMM [NV] = '{8'h00, 8'hFF, 8'hA5, 8'hF2, 8'hFE, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
  localparam logic [VW-1:0] T_MSK [NV] = '{
    128'h8000_0000_0000_0000_0000_0000_0000_00FF,
    128'h7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F,
    {VW{1'b1}}, {VW{1'b1}}, {VW{1'b1}},
    128'h8000_0000_0000_0000_0000_00FF_7FFF_FFFF,
    128'h0000_0000_8000_0000_8000_0000_0000_0000,
    {VW{1'b1}}, {VW{1'b1}}};
  localparam logic [VW-1:0] T_EXP [NV] = '{
    128'hFF00_0000_0000_0000_0000_0000_0000_00FF,
    128'h0,
    128'hFFFF_0000_FFFF_0000_0000_FFFF_0000_FFFF,
    128'h0000_0000_0000_0000_FFFF_FFFF_0000_0000,
    128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000,
    128'hFFFF_FFFF_0000_0000_0000_0000_0000_0000,
    128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF,
    128'h0, 128'h0};

  function automatic string op_req(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [VW-1:0] ref_blend(input logic [2:0] o, input logic [7:0] im,
      input logic [VW-1:0] m, input logic [VW-1:0] d, input logic [VW-1:0] s);
    logic [VW-1:0] r;
    for (int b = 0; b < VW/8; b++) begin
      logic t;
      case (o)
        3'd0: t = m[8*b + 7];
        3'd1: t = im[b/2];
        3'd2: t = im[b/4];
        3'd3: t = im[b/8];
        3'd4: t = m[32*(b/4) + 31];
        3'd5: t = m[64*(b/8) + 63];
        default: t = 1'b0;
      endcase
      r[8*b +: 8] = t ? s[8*b +: 8] : d[8*b +: 8];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the result visible
  task automatic issue(input logic [2:0] o, input logic [7:0] im, input logic [VW-1:0] m,
      input logic [VW-1:0] d, input logic [VW-1:0] s);
    op = o; imm = im; msk = m; dst = d; src = s; in_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [VW-1:0] pd, ps, pm, held;
    pd = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    ps = 128'hA5A5_5A5A_C3C3_3C3C_0F0F_F0F0_9696_6969;
    pm = 128'h8F00_7F80_0080_FF00_7FFF_8000_00FF_8001;

    repeat (3) @(negedge clk);
    chk("R11", {127'b0, out_valid}, '0);
    chk("R11", res, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      issue(T_OP[i], T_IMM[i], T_MSK[i], '0, {VW{1'b1}});
      chk("R9", {127'b0, out_valid}, 128'd1);
      chk(op_req(T_OP[i]), res, T_EXP[i]);
    end

    // distinct data per opcode, back to back
    for (int o = 0; o < 8; o++) begin
      issue(3'(o), 8'h5A, pm, pd, ps);
      chk("R9", {127'b0, out_valid}, 128'd1);
      chk(op_req(3'(o)), res, ref_blend(3'(o), 8'h5A, pm, pd, ps));
    end

    // R7: ignored operand changes
    issue(3'd1, 8'h33, pm, pd, ps);
    chk("R7", res, ref_blend(3'd1, 8'h33, '0, pd, ps));
    issue(3'd1, 8'h33, ~pm, pd, ps);
    chk("R7", res, ref_blend(3'd1, 8'h33, '0, pd, ps));
    issue(3'd3, 8'hFD, ~pm, pd, ps);
    chk("R4", res, ref_blend(3'd3, 8'h01, '0, pd, ps));
    issue(3'd4, 8'h00, pm, pd, ps);
    chk("R7", res, ref_blend(3'd4, 8'h00, pm, pd, ps));
    issue(3'd4, 8'hFF, pm, pd, ps);
    chk("R7", res, ref_blend(3'd4, 8'h00, pm, pd, ps));
    issue(3'd5, 8'hFF, ~pm, pd, ps);
    chk("R6", res, ref_blend(3'd5, 8'h00, ~pm, pd, ps));

    // R10: idle with changing inputs
    held = res;
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      op = 3'(k); imm = 8'(k * 37); dst = ps ^ 128'(k); src = pd; msk = ~pm;
      @(negedge clk);
      chk("R10", {127'b0, out_valid}, '0);
      chk("R10", res, held);
    end

    // R9: valid pulse after idle
    issue(3'd0, 8'h00, {VW{1'b1}}, pd, ps);
    chk("R9", {127'b0, out_valid}, 128'd1);
    chk("R1", res, ps);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", {127'b0, out_valid}, '0);

    // R11: reset mid-run clears state
    rst_n = 1'b0;
    #1;
    chk("R11", res, '0);
    chk("R11", {127'b0, out_valid}, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule